// File: doc/BRIEF.md
# Dual Down-Counting Timer with Free-Running Timestamp

This peripheral gives a processor three time bases behind one small register bus. A free-running timestamp counter advances once every clock, and software may overwrite it at any time. Two down-counting timers are controlled separately. Each timer can expire once or repeatedly, and every expiry sets a sticky pending flag in a shared status word. The timestamp also sets a flag of its own when it wraps.

Each timer has a reload word and a current-count word. The two low bits of the reload word hold the timer's controls: bit 0 enables the timer and bit 1 selects single-shot mode (1) or repeating mode (0). These two bits are read as zero when the reload value is loaded into the counter, so every period is a multiple of four clocks. Software starts a new event by rewriting the reload word with the same low bits. The interrupt output is the OR of all pending flags. A handler clears a flag by writing a 1 to its status bit.

The bus uses an address, a write strobe and write data. Writes take effect on the clock edge where the strobe is high. Read data is combinational from the address. Word offsets:
- 0x00: timestamp
- 0x04: timer A count
- 0x08: timer A reload
- 0x0C: timer B count
- 0x10: timer B reload
- 0x20: status

Top module: `dual_os_timer`

## Requirements
- R1: While reset is high, the timestamp, both counts, both reload words and the status word all read 0, and `irq_o` is low.
- R2: The timestamp rises by one on every clock edge. A write to offset 0x00 makes it hold the written value after that edge, and it counts on from there.
- R3: When the timestamp steps from 0xFFFFFFFF to 0, status bit 2 becomes 1.
- R4: A write to a reload word with bit 0 set loads the written value, with bits 1:0 forced to 0, into that timer's count on the same edge. The count then falls by one per clock, can be read at the timer's count offset, and the full reload word, including its low bits, reads back at the reload offset.
- R5: With a loaded value N (N ≥ 4), the timer's pending flag becomes 1 exactly N edges after the loading write, and not before. Timer A uses status bit 0 and timer B uses status bit 1.
- R6: In repeating mode (bit 1 = 0), the count is reloaded to N on the expiry edge, and the flag sets again every N edges.
- R7: In single-shot mode (bit 1 = 1), the count stops at 0 after expiry and bit 0 of the reload word reads back as 0. Bit 1 and the count bits keep their values.
- R8: A write of 0 to a reload word stops that timer. Its count holds its value and it sets no further flags.
- R9: Writing the status word clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R10: If a flag is being set and cleared on the same edge, the set wins and the flag stays 1.
- R11: `irq_o` is high exactly when at least one status bit is 1.
- R12: Offsets other than the six listed read as 0, and writes to them change no state.
- R13: The two timers run independently. One timer's count, control and flag are unaffected by the other timer's activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | ADDR_W | Byte offset of the accessed word |
| bus_wr_i | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | High while any status bit is set |

## Verification
An expiry that sets a pending flag and a software write that clears the same flag can land on the same clock edge. The bench tracks edge counts from the loading write of a repeating 8-clock timer. It places a clear of that timer's flag exactly on the 16th edge, where the second expiry happens. The status word read afterwards must still show the flag. A second clear, one edge later, must remove it.

// File: rtl/ostmr_pkg.sv
`timescale 1ns/1ps
package ostmr_pkg;
  localparam int unsigned NUM_TMR   = 2;
  localparam int unsigned STAT_BITS = NUM_TMR + 1;
  localparam int unsigned CTL_BITS  = 2;

  localparam int unsigned OFS_STAMP = 32'h00;
  localparam int unsigned OFS_STAT  = 32'h20;

  typedef enum logic {
    MODE_REPEAT = 1'b0,
    MODE_SINGLE = 1'b1
  } tmr_mode_e;

  // timers sit in pairs of words: count then reload
  function automatic int unsigned cur_ofs(int unsigned idx);
    return 32'h04 + 32'h08 * idx;
  endfunction

  function automatic int unsigned rld_ofs(int unsigned idx);
    return 32'h08 + 32'h08 * idx;
  endfunction
endpackage

// File: rtl/ostmr_stamp.sv
`timescale 1ns/1ps
module ostmr_stamp #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)     val_q <= '0;
    else if (wr_i) val_q <= wd_i;
    else           val_q <= val_q + W'(1);
  end

  assign val_o  = val_q;
  assign wrap_o = !wr_i && (val_q == '1);

  // R2
  stamp_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> val_o == $past(val_o) + W'(1));

  // R2
  stamp_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i |=> val_o == $past(wd_i));
endmodule

// File: rtl/ostmr_down.sv
`timescale 1ns/1ps
module ostmr_down
  import ostmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ctl_o,
  output logic         expire_o
);
  logic [W-1:0] rld_q, cnt_q;
  logic [W-1:0] rld_base, wd_base;
  logic         run, single;

  assign run      = rld_q[0];
  assign single   = (tmr_mode_e'(rld_q[1]) == MODE_SINGLE);
  assign rld_base = {rld_q[W-1:CTL_BITS], {CTL_BITS{1'b0}}};
  assign wd_base  = {wd_i[W-1:CTL_BITS], {CTL_BITS{1'b0}}};
  assign expire_o = run && !wr_i && (cnt_q <= W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rld_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      rld_q <= wd_i;
      if (wd_i[0]) cnt_q <= wd_base;
    end else if (expire_o) begin
      if (single) begin
        rld_q[0] <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= rld_base;
      end
    end else if (run) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign ctl_o = rld_q;

  // R4
  dn_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run && !wr_i && cnt_q > W'(1)) |=> cnt_q == $past(cnt_q) - W'(1));

  // R7
  dn_single_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire_o && single) |=> (!ctl_o[0] && cnt_o == '0));

  // R6
  dn_repeat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire_o && !single) |=> cnt_o == $past(rld_base));

  // R8
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run && !wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dual_os_timer.sv
`timescale 1ns/1ps
module dual_os_timer
  import ostmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(OFS_STAMP);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

  logic [CNT_W-1:0]     stamp;
  logic                 stamp_wrap;
  logic [CNT_W-1:0]     tcnt [NUM_TMR];
  logic [CNT_W-1:0]     tctl [NUM_TMR];
  logic [NUM_TMR-1:0]   texp;
  logic [STAT_BITS-1:0] pend_q, set_vec, clr_vec;

  ostmr_stamp #(.W(CNT_W)) u_stamp (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wr_i   (bus_wr_i && bus_addr_i == A_STAMP),
    .wd_i   (bus_wdata_i),
    .val_o  (stamp),
    .wrap_o (stamp_wrap)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(rld_ofs(t));
    ostmr_down #(.W(CNT_W)) u_down (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_i     (bus_wr_i && bus_addr_i == A_RLD),
      .wd_i     (bus_wdata_i),
      .cnt_o    (tcnt[t]),
      .ctl_o    (tctl[t]),
      .expire_o (texp[t])
    );
  end

  assign set_vec = {stamp_wrap, texp};
  assign clr_vec = (bus_wr_i && bus_addr_i == A_STAT) ? bus_wdata_i[STAT_BITS-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q <= '0;
    else       pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  assign irq_o = |pend_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_STAMP) bus_rdata_o = stamp;
    if (bus_addr_i == A_STAT)  bus_rdata_o = CNT_W'(pend_q);
    for (int t = 0; t < NUM_TMR; t++) begin
      if (bus_addr_i == ADDR_W'(cur_ofs(t))) bus_rdata_o = tcnt[t];
      if (bus_addr_i == ADDR_W'(rld_ofs(t))) bus_rdata_o = tctl[t];
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_vec != '0) |=> (pend_q & $past(set_vec)) == $past(set_vec));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_vec != '0 && set_vec == '0) |=> (pend_q & $past(clr_vec)) == '0);

  // R11
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_o) |-> $past(set_vec != '0));
endmodule

// File: tb/dual_os_timer_test.sv
`timescale 1ns/1ps
module dual_os_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  dual_os_timer uut (
    .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wd), .bus_rdata_o(rd), .irq_o(irq)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t exp_q[$];
  event  smp_ev;
  int    n_run = 0, n_fail = 0;
  int unsigned last_w = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with read data
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(it.req, rd, it.exp);
    end
  end

  // driver: present address, queue the expected word
  task automatic look(logic [7:0] a, logic [31:0] exp, string req);
    item_t it;
    addr = a;
    #0.1;
    it.exp = exp;
    it.req = req;
    exp_q.push_back(it);
    -> smp_ev;
    #0.1;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    last_w = cyc;
  endtask

  task automatic wait_to(int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned w, w1;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    look(8'h00, 32'h0, "R1 stamp");
    look(8'h20, 32'h0, "R1 status");
    look(8'h08, 32'h0, "R1 reload A");
    look(8'h0C, 32'h0, "R1 count B");
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R2 timestamp load and count
    bus_wr(8'h00, 32'd100); w = last_w;
    repeat (3) @(negedge clk);
    look(8'h00, 32'd100 + (cyc - w), "R2 count");
    repeat (5) @(negedge clk);
    look(8'h00, 32'd100 + (cyc - w), "R2 count later");

    // R3 wrap flag
    bus_wr(8'h00, 32'hFFFF_FFFC); w = last_w;
    wait_to(w + 3);
    look(8'h20, 32'h0, "R3 no early flag");
    wait_to(w + 4);
    look(8'h20, 32'h4, "R3 wrap flag");
    check("R11 irq on", {31'b0, irq}, 32'h1);
    bus_wr(8'h20, 32'h4);
    look(8'h20, 32'h0, "R9 clear wrap");
    check("R11 irq off", {31'b0, irq}, 32'h0);

    // R4 R5 R6 timer A repeating, value 0x15 -> count 20
    bus_wr(8'h08, 32'h15); w = last_w;
    repeat (2) @(negedge clk);
    look(8'h04, 32'd20 - (cyc - w), "R4 countdown");
    look(8'h08, 32'h15, "R4 reload readback");
    wait_to(w + 19);
    look(8'h20, 32'h0, "R5 not early");
    wait_to(w + 20);
    look(8'h20, 32'h1, "R5 expiry A");
    check("R11 irq timer", {31'b0, irq}, 32'h1);
    look(8'h04, 32'd20, "R6 reloaded");
    look(8'h0C, 32'h0, "R13 B untouched");
    bus_wr(8'h20, 32'h0);
    look(8'h20, 32'h1, "R9 zero write keeps");
    bus_wr(8'h20, 32'h1);
    look(8'h20, 32'h0, "R9 clear A");
    wait_to(w + 40);
    look(8'h20, 32'h1, "R6 second expiry");
    look(8'h04, 32'd20, "R6 reload again");

    // R8 disable freezes
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h20, 32'h1);
    addr = 8'h04; #0.1; held = rd;
    repeat (30) @(negedge clk);
    look(8'h04, held, "R8 count held");
    look(8'h20, 32'h0, "R8 no flag");

    // R7 timer B single-shot, 0x0B -> count 8
    bus_wr(8'h10, 32'h0B); w = last_w;
    wait_to(w + 7);
    look(8'h0C, 32'h1, "R7 count before");
    look(8'h20, 32'h0, "R5 B not early");
    wait_to(w + 8);
    look(8'h20, 32'h2, "R5 expiry B");
    look(8'h0C, 32'h0, "R7 stopped");
    look(8'h10, 32'h0A, "R7 enable cleared");
    repeat (20) @(negedge clk);
    look(8'h0C, 32'h0, "R7 stays stopped");
    look(8'h20, 32'h2, "R7 single flag only");
    bus_wr(8'h20, 32'h2);
    look(8'h20, 32'h0, "R9 clear B");
    check("R11 irq cleared", {31'b0, irq}, 32'h0);

    // R10 set and clear on the same edge, timer B repeating 8
    bus_wr(8'h10, 32'h09); w = last_w;
    wait_to(w + 8);
    look(8'h20, 32'h2, "R10 first expiry");
    bus_wr(8'h20, 32'h2);
    look(8'h20, 32'h0, "R10 cleared");
    wait_to(w + 15);
    bus_wr(8'h20, 32'h2);
    look(8'h20, 32'h2, "R10 set wins");
    bus_wr(8'h20, 32'h2);
    look(8'h20, 32'h0, "R10 later clear");
    bus_wr(8'h10, 32'h0);

    // R13 both timers at once: A 12, B 8
    bus_wr(8'h08, 32'h0D); w1 = last_w;
    bus_wr(8'h10, 32'h09);
    wait_to(w1 + 9);
    look(8'h20, 32'h2, "R13 B alone");
    look(8'h04, 32'd3, "R13 A count");
    wait_to(w1 + 12);
    look(8'h20, 32'h3, "R13 both");
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h10, 32'h0);
    bus_wr(8'h20, 32'h7);
    look(8'h20, 32'h0, "R13 all clear");

    // R12 unmapped offsets
    look(8'h14, 32'h0, "R12 read 0x14");
    look(8'h24, 32'h0, "R12 read 0x24");
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_wr(8'h30, 32'hFFFF_FFFF);
    look(8'h14, 32'h0, "R12 after write");
    look(8'h08, 32'h0, "R12 reload A intact");
    look(8'h10, 32'h0, "R12 reload B intact");
    look(8'h20, 32'h0, "R12 status intact");
    check("R12 irq", {31'b0, irq}, 32'h0);

    @(negedge clk);
    finish_run();
  end
endmodule